// File: doc/BRIEF.md
# MMU Fault-Capture and Entry-Staging Registers

This block holds the memory-management control registers of a 32-bit processor. It has five word registers, reached only by absolute addresses at the top of the address space: a translation control word, an entry-high word, an entry-low word, a table-base word and a fault-address word. The entry-high word holds a virtual page number and the number of the running process. The entry-low word holds the physical page number and the page attributes. The table-base word is scratch storage for software.

When the core reports a translation or address-error fault, the block records the full faulting virtual address in the fault-address word. It also copies the upper 22 address bits into the page-number field of the entry-high word. A load strobe snapshots the staged entry (page number, process number and entry-low word) onto an output bundle for the translation buffer. User-mode accesses to any of these addresses are refused and flagged.

Top module: `mmu_capture_regs`

## Requirements
- R1: Privileged accesses decode these addresses: control word H'FFFFFFE0, entry-high H'FFFFFFF0, entry-low H'FFFFFFF4, table-base H'FFFFFFF8, fault-address H'FFFFFFFC. A privileged read returns the addressed register on `accRdata` in the same cycle. Any other address reads as zero and raises no violation.
- R2: A user-mode access (`accPriv`=0) to any decoded address writes nothing, returns zero and drives `accViolation` high in that cycle.
- R3: On `excValid`, entry-high bits 31:10 take `excAddr[31:10]` at the next edge, and its process field is left unchanged.
- R4: On `excValid`, the fault-address word takes all 32 bits of `excAddr` and then holds them until the next `excValid`. Software writes to it are ignored.
- R5: A software write to entry-high stores bits 31:10 (page number) and bits 7:0 (process number). Bits 9:8 always read as zero.
- R6: The entry-low and table-base words are full 32-bit software registers that no exception changes.
- R7: If `excValid` coincides with a privileged write to entry-high, the exception capture wins and the whole software write to entry-high is dropped.
- R8: One edge after `tlbLoad`, `tlbValid` is high for one cycle. At that point `tlbVpn`, `tlbAsid` and `tlbLow` show the page number, process number and entry-low word as they stood before that edge.
- R9: In the control word, bit 0 is a read/write enable that drives `mmuEnable`. Writing 1 to bit 2 pulses `tlbFlush` for one cycle after the edge. Bit 2 and all other bits read as zero.
- R10: After reset every register is zero, and `mmuEnable`, `tlbFlush` and `tlbValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Register access request |
| accWrite | input | 1 | 1 = write, 0 = read |
| accPriv | input | 1 | Access comes from privileged mode |
| accAddr | input | 32 | Absolute access address |
| accWdata | input | 32 | Write data |
| accRdata | output | 32 | Read data (combinational) |
| accViolation | output | 1 | User-mode access to a decoded address |
| excValid | input | 1 | Translation or address-error fault strobe |
| excAddr | input | 32 | Faulting virtual address |
| tlbLoad | input | 1 | Request to emit the staged entry |
| tlbValid | output | 1 | Staged entry valid this cycle |
| tlbVpn | output | 22 | Staged virtual page number |
| tlbAsid | output | 8 | Staged process number |
| tlbLow | output | 32 | Staged entry-low word |
| mmuEnable | output | 1 | Translation enable bit |
| tlbFlush | output | 1 | One-cycle flush request |

## Verification
The bench builds the block with its default parameters: an 8-bit process field and a page number starting at bit 10. With these values there are two always-zero bits between the two fields, so writing all ones to entry-high shows whether the gap is kept. With a 22-bit page number, a fault address whose low ten bits are non-zero separates the page-number capture from the full-address capture. A fault that lands in the same cycle as a software write to entry-high exercises the priority rule.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;

  localparam logic [31:0] CTL_ADDR   = 32'hFFFF_FFE0;
  localparam logic [31:0] HI_ADDR    = 32'hFFFF_FFF0;
  localparam logic [31:0] LO_ADDR    = 32'hFFFF_FFF4;
  localparam logic [31:0] BASE_ADDR  = 32'hFFFF_FFF8;
  localparam logic [31:0] FAULT_ADDR = 32'hFFFF_FFFC;

  localparam int EN_BIT    = 0;
  localparam int FLUSH_BIT = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTL,
    SEL_HI,
    SEL_LO,
    SEL_BASE,
    SEL_FAULT
  } regSel_e;

  typedef struct packed {
    logic    wrHi;
    logic    wrLo;
    logic    wrBase;
    logic    wrCtl;
    logic    capture;
    logic    load;
    regSel_e rdSel;
  } ctlStrobes_t;

endpackage

// File: rtl/mmu_ctl.sv
module mmu_ctl
  import mmu_regs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic              accPriv,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              excValid,
  input  logic              tlbLoad,
  output ctlStrobes_t       strb,
  output logic              accViolation
);

  regSel_e sel;
  logic    hit;
  logic    privOk;
  logic    wrOk;

  always_comb begin
    sel = SEL_NONE;
    case (accAddr)
      ADDR_W'(CTL_ADDR):   sel = SEL_CTL;
      ADDR_W'(HI_ADDR):    sel = SEL_HI;
      ADDR_W'(LO_ADDR):    sel = SEL_LO;
      ADDR_W'(BASE_ADDR):  sel = SEL_BASE;
      ADDR_W'(FAULT_ADDR): sel = SEL_FAULT;
      default:             sel = SEL_NONE;
    endcase
  end

  assign hit    = (sel != SEL_NONE);
  assign privOk = accValid & accPriv & hit;
  assign wrOk   = privOk & accWrite;

  always_comb begin
    strb.capture = excValid;
    strb.load    = tlbLoad;
    strb.wrHi    = wrOk & (sel == SEL_HI) & ~excValid;
    strb.wrLo    = wrOk & (sel == SEL_LO);
    strb.wrBase  = wrOk & (sel == SEL_BASE);
    strb.wrCtl   = wrOk & (sel == SEL_CTL);
    strb.rdSel   = (privOk & ~accWrite) ? sel : SEL_NONE;
  end

  assign accViolation = accValid & ~accPriv & hit;

  // R2
  user_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accPriv) |->
      !(strb.wrHi || strb.wrLo || strb.wrBase || strb.wrCtl) && (strb.rdSel == SEL_NONE));

  // R7
  capture_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> !strb.wrHi);

  // R2
  violation_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!accValid || accPriv) |-> !accViolation);

endmodule

// File: rtl/mmu_dp.sv
module mmu_dp
  import mmu_regs_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ASID_W  = 8,
  parameter int VPN_LSB = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobes_t               strb,
  input  logic [ADDR_W-1:0]         accWdata,
  input  logic [ADDR_W-1:0]         excAddr,
  output logic [ADDR_W-1:0]         accRdata,
  output logic                      mmuEnable,
  output logic                      tlbFlush,
  output logic                      tlbValid,
  output logic [ADDR_W-VPN_LSB-1:0] tlbVpn,
  output logic [ASID_W-1:0]         tlbAsid,
  output logic [ADDR_W-1:0]         tlbLow
);

  localparam int VPN_W = ADDR_W - VPN_LSB;
  localparam int GAP_W = VPN_LSB - ASID_W;

  logic [VPN_W-1:0]  vpnQ;
  logic [ASID_W-1:0] asidQ;
  logic [ADDR_W-1:0] lowQ;
  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] faultQ;
  logic              enQ;
  logic [ADDR_W-1:0] hiWord;
  logic [ADDR_W-1:0] ctlWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnQ     <= '0;
      asidQ    <= '0;
      lowQ     <= '0;
      baseQ    <= '0;
      faultQ   <= '0;
      enQ      <= 1'b0;
      tlbFlush <= 1'b0;
      tlbValid <= 1'b0;
      tlbVpn   <= '0;
      tlbAsid  <= '0;
      tlbLow   <= '0;
    end else begin
      if (strb.capture) begin
        vpnQ   <= excAddr[ADDR_W-1:VPN_LSB];
        faultQ <= excAddr;
      end else if (strb.wrHi) begin
        vpnQ  <= accWdata[ADDR_W-1:VPN_LSB];
        asidQ <= accWdata[ASID_W-1:0];
      end
      if (strb.wrLo)   lowQ  <= accWdata;
      if (strb.wrBase) baseQ <= accWdata;
      if (strb.wrCtl)  enQ   <= accWdata[EN_BIT];
      tlbFlush <= strb.wrCtl & accWdata[FLUSH_BIT];
      tlbValid <= strb.load;
      if (strb.load) begin
        tlbVpn  <= vpnQ;
        tlbAsid <= asidQ;
        tlbLow  <= lowQ;
      end
    end
  end

  assign mmuEnable = enQ;
  assign hiWord    = {vpnQ, {GAP_W{1'b0}}, asidQ};

  always_comb begin
    ctlWord         = '0;
    ctlWord[EN_BIT] = enQ;
  end

  always_comb begin
    case (strb.rdSel)
      SEL_CTL:   accRdata = ctlWord;
      SEL_HI:    accRdata = hiWord;
      SEL_LO:    accRdata = lowQ;
      SEL_BASE:  accRdata = baseQ;
      SEL_FAULT: accRdata = faultQ;
      default:   accRdata = '0;
    endcase
  end

  // R4
  fault_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> faultQ == $past(excAddr));

  // R4
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(faultQ));

  // R6
  base_sw_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrBase |=> $stable(baseQ));

  // R8
  tlb_snapshot_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> tlbValid && tlbLow == $past(lowQ) && tlbAsid == $past(asidQ));

  // R9
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tlbFlush) |-> $past(strb.wrCtl));

endmodule

// File: rtl/mmu_capture_regs.sv
module mmu_capture_regs
  import mmu_regs_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ASID_W  = 8,
  parameter int VPN_LSB = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      accValid,
  input  logic                      accWrite,
  input  logic                      accPriv,
  input  logic [ADDR_W-1:0]         accAddr,
  input  logic [ADDR_W-1:0]         accWdata,
  output logic [ADDR_W-1:0]         accRdata,
  output logic                      accViolation,
  input  logic                      excValid,
  input  logic [ADDR_W-1:0]         excAddr,
  input  logic                      tlbLoad,
  output logic                      tlbValid,
  output logic [ADDR_W-VPN_LSB-1:0] tlbVpn,
  output logic [ASID_W-1:0]         tlbAsid,
  output logic [ADDR_W-1:0]         tlbLow,
  output logic                      mmuEnable,
  output logic                      tlbFlush
);

  ctlStrobes_t strb;

  mmu_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN),
    .accValid(accValid), .accWrite(accWrite), .accPriv(accPriv), .accAddr(accAddr),
    .excValid(excValid), .tlbLoad(tlbLoad),
    .strb(strb), .accViolation(accViolation)
  );

  mmu_dp #(.ADDR_W(ADDR_W), .ASID_W(ASID_W), .VPN_LSB(VPN_LSB)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .accWdata(accWdata), .excAddr(excAddr), .accRdata(accRdata),
    .mmuEnable(mmuEnable), .tlbFlush(tlbFlush),
    .tlbValid(tlbValid), .tlbVpn(tlbVpn), .tlbAsid(tlbAsid), .tlbLow(tlbLow)
  );

endmodule

// File: tb/mmu_capture_regs_bench.sv
module mmu_capture_regs_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        accValid, accWrite, accPriv;
  logic [31:0] accAddr, accWdata, accRdata;
  logic        accViolation;
  logic        excValid;
  logic [31:0] excAddr;
  logic        tlbLoad, tlbValid;
  logic [21:0] tlbVpn;
  logic [7:0]  tlbAsid;
  logic [31:0] tlbLow;
  logic        mmuEnable, tlbFlush;

  int nChecks = 0;
  int nErr    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_capture_regs u_mmu_capture_regs (
    .clk(clk), .rstN(rstN),
    .accValid(accValid), .accWrite(accWrite), .accPriv(accPriv),
    .accAddr(accAddr), .accWdata(accWdata), .accRdata(accRdata),
    .accViolation(accViolation),
    .excValid(excValid), .excAddr(excAddr),
    .tlbLoad(tlbLoad), .tlbValid(tlbValid), .tlbVpn(tlbVpn),
    .tlbAsid(tlbAsid), .tlbLow(tlbLow),
    .mmuEnable(mmuEnable), .tlbFlush(tlbFlush)
  );

  typedef struct packed {
    logic        wr;
    logic        priv;
    logic [31:0] addr;
    logic [31:0] data;   // write data, or expected read data
    logic        viol;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 32'hFFFF_FFF4, 32'hA5A5_1234, 1'b0, 4'd6},  // R6 write entry-low
    '{1'b0, 1'b1, 32'hFFFF_FFF4, 32'hA5A5_1234, 1'b0, 4'd1},  // R1 read entry-low
    '{1'b1, 1'b1, 32'hFFFF_FFF8, 32'h0BAD_F00D, 1'b0, 4'd6},  // R6 write table-base
    '{1'b0, 1'b1, 32'hFFFF_FFF8, 32'h0BAD_F00D, 1'b0, 4'd1},  // R1 read table-base
    '{1'b1, 1'b1, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 1'b0, 4'd5},  // R5 all ones
    '{1'b0, 1'b1, 32'hFFFF_FFF0, 32'hFFFF_FCFF, 1'b0, 4'd5},  // R5 gap reads zero
    '{1'b1, 1'b0, 32'hFFFF_FFF4, 32'h0000_0000, 1'b1, 4'd2},  // R2 user write
    '{1'b0, 1'b1, 32'hFFFF_FFF4, 32'hA5A5_1234, 1'b0, 4'd2},  // R2 unchanged
    '{1'b0, 1'b0, 32'hFFFF_FFF8, 32'h0000_0000, 1'b1, 4'd2},  // R2 user read zero
    '{1'b0, 1'b1, 32'hFFFF_FFF8, 32'h0BAD_F00D, 1'b0, 4'd2},  // R2 unchanged
    '{1'b1, 1'b1, 32'hFFFF_FFFC, 32'h1234_5678, 1'b0, 4'd4},  // R4 sw write ignored
    '{1'b0, 1'b1, 32'hFFFF_FFFC, 32'h0000_0000, 1'b0, 4'd4},  // R4 still zero
    '{1'b0, 1'b1, 32'hFFFF_FFEC, 32'h0000_0000, 1'b0, 4'd1},  // R1 unmapped
    '{1'b1, 1'b1, 32'hFFFF_FFE0, 32'hFFFF_FFF9, 1'b0, 4'd9},  // R9 enable, no flush
    '{1'b0, 1'b1, 32'hFFFF_FFE0, 32'h0000_0001, 1'b0, 4'd9}   // R9 only bit 0 reads
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic priv, input logic [31:0] addr,
                        input logic [31:0] data, output logic [31:0] rd, output logic viol);
    @(negedge clk);
    accValid = 1'b1; accWrite = wr; accPriv = priv; accAddr = addr; accWdata = data;
    #1;
    rd = accRdata; viol = accViolation;
    @(posedge clk); #1;
    accValid = 1'b0; accWrite = 1'b0;
  endtask

  task automatic rd(input logic [31:0] addr, output logic [31:0] val);
    logic v;
    access(1'b0, 1'b1, addr, 32'h0, val, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic        v;
    logic [31:0] fa;
    rstN = 1'b0; accValid = 0; accWrite = 0; accPriv = 0; accAddr = 0; accWdata = 0;
    excValid = 0; excAddr = 0; tlbLoad = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R10 reset state
    check("R10", {29'b0, mmuEnable, tlbFlush, tlbValid}, 32'h0);
    rd(32'hFFFF_FFE0, r); check("R10", r, 32'h0);
    rd(32'hFFFF_FFF0, r); check("R10", r, 32'h0);
    rd(32'hFFFF_FFF4, r); check("R10", r, 32'h0);
    rd(32'hFFFF_FFF8, r); check("R10", r, 32'h0);
    rd(32'hFFFF_FFFC, r); check("R10", r, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i].wr, VECS[i].priv, VECS[i].addr, VECS[i].data, r, v);
      check($sformatf("R%0d", VECS[i].req), {31'b0, v}, {31'b0, VECS[i].viol});
      if (!VECS[i].wr) check($sformatf("R%0d", VECS[i].req), r, VECS[i].data);
    end
    check("R9", {31'b0, mmuEnable}, 32'h1);
    check("R9", {31'b0, tlbFlush}, 32'h0);

    // R3 R4 exception capture; process field stays FF
    fa = 32'h1234_5ABC;
    @(negedge clk); excValid = 1'b1; excAddr = fa;
    @(posedge clk); #1; excValid = 1'b0;
    rd(32'hFFFF_FFF0, r); check("R3", r, (fa & 32'hFFFF_FC00) | 32'h0000_00FF);
    rd(32'hFFFF_FFFC, r); check("R4", r, fa);
    excAddr = 32'hDEAD_BEEF;
    repeat (3) @(posedge clk);
    rd(32'hFFFF_FFFC, r); check("R4", r, fa);
    rd(32'hFFFF_FFF4, r); check("R6", r, 32'hA5A5_1234);
    rd(32'hFFFF_FFF8, r); check("R6", r, 32'h0BAD_F00D);

    // R7 exception and software write to entry-high in the same cycle
    fa = 32'hCAFE_B123;
    @(negedge clk);
    excValid = 1'b1; excAddr = fa;
    accValid = 1'b1; accWrite = 1'b1; accPriv = 1'b1; accAddr = 32'hFFFF_FFF0; accWdata = 32'h0000_0011;
    @(posedge clk); #1;
    excValid = 1'b0; accValid = 1'b0; accWrite = 1'b0;
    rd(32'hFFFF_FFF0, r); check("R7", r, 32'hCAFE_B0FF);
    rd(32'hFFFF_FFFC, r); check("R7", r, fa);

    // R8 staged entry output
    @(negedge clk); tlbLoad = 1'b1;
    @(posedge clk); #1; tlbLoad = 1'b0;
    check("R8", {31'b0, tlbValid}, 32'h1);
    check("R8", {10'b0, tlbVpn}, fa >> 10);
    check("R8", {24'b0, tlbAsid}, 32'h0000_00FF);
    check("R8", tlbLow, 32'hA5A5_1234);
    @(posedge clk); #1;
    check("R8", {31'b0, tlbValid}, 32'h0);

    // R9 flush pulse, enable cleared by same write
    access(1'b1, 1'b1, 32'hFFFF_FFE0, 32'h0000_0004, r, v);
    check("R9", {31'b0, tlbFlush}, 32'h1);
    check("R9", {31'b0, mmuEnable}, 32'h0);
    rd(32'hFFFF_FFE0, r); check("R9", r, 32'h0);
    check("R9", {31'b0, tlbFlush}, 32'h0);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule